// File: doc/BRIEF.md
# Four-Lane Shared Twiddle/Phase Complex Multiplier

This stage sits between a four-point-per-cycle transform array and the result store. Every accepted beat carries four complex samples. Each sample is multiplied by its own complex coefficient. On a column pass the coefficient comes from an on-chip table of inter-stage twiddle factors. On a row pass it is taken from a phase-function stream supplied next to the data. The same four multipliers serve both passes. Feeding a phase coefficient of one therefore gives a plain transform with no compensation.

A vector is N points long and arrives as N/4 consecutive accepted beats. The pass is chosen once per vector, on its first beat. Beats move through a three-stage pipeline under a single valid/ready handshake that is shared by all four lanes. When the output is stalled, the whole pipeline holds.

Top module: `phase_twiddle_mul`

## Requirements
- R1: The reset `rst` is synchronous and active high. During and directly after reset, `out_valid_o` is 0 and `in_ready_o` is 1. Reset also restarts the beat count, so the next accepted beat is the first beat of a vector.
- R2: Lane k occupies bits [32k+31:32k] of `data_i`, `phase_i` and `data_o`. Bits [31:16] of each lane hold the real part and bits [15:0] hold the imaginary part, both signed Q1.15. Each output lane is the complex product of its data sample and its coefficient.
- R3: Each product component is formed at full precision, then rounded by adding 2^14 and shifting right arithmetically by 15. Exact halves therefore round toward +infinity: 1.5 LSB gives 2 and -1.5 LSB gives -1.
- R4: A rounded component above 32767 is clamped to 32767. A rounded component below -32768 is clamped to -32768.
- R5: When the phase pass is active, the coefficient for lane k is lane k of `phase_i` in the same beat.
- R6: When the twiddle pass is active, the coefficient for lane k of beat n (n = 0 to N/4-1 within the vector) is exp(-j·2π·m/N) with m = (n·k) mod N. Both parts are rounded to Q1.15 and held to at most 32767.
- R7: `pass_sel_i` is sampled only on the first beat of each vector (1 = phase pass, 0 = twiddle pass). On the other N/4-1 beats it has no effect.
- R8: A coefficient of (32767, 0) returns every data component in [-16383, 16384] unchanged, which gives the transform-only mode. The value -32768 comes back as -32767.
- R9: When `out_ready_i` is high, a beat accepted in cycle t appears on `data_o` with `out_valid_o` high in cycle t+3.
- R10: While `out_valid_o` is high and `out_ready_i` is low, `data_o` holds its value. Beats are neither lost nor reordered. `in_ready_o` is high whenever `out_ready_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pass_sel_i | input | 1 | Pass choice for the vector, used only on its first beat |
| in_valid_i | input | 1 | Input beat valid |
| in_ready_o | output | 1 | Stage can accept a beat |
| data_i | input | 128 | Four complex transform samples |
| phase_i | input | 128 | Four complex phase coefficients |
| out_valid_o | output | 1 | Output beat valid |
| out_ready_i | input | 1 | Downstream accepts the output beat |
| data_o | output | 128 | Four complex products |

## Verification
The bench drives operand pairs at the extremes of Q1.15. Examples are -1 times -1 and a sum of two near-full-scale products. A design that wraps instead of clamping would output a large value with the wrong sign. The bench also drives exact-half products, where a truncating or symmetric rounder differs by one LSB. A twiddle vector is sent with the selector held at the phase setting on every beat after the first, and with a zero phase stream. A design that samples the selector on every beat would output zeros. A twiddle index built from the wrong beat or lane gives visibly wrong rotations. The remaining tests cover a stall with three beats in flight (a lost or repeated beat breaks the order), an exact three-cycle latency probe, and a reset in mid-vector that must restart the beat count at zero.

// File: rtl/ptm_pkg.sv
package ptm_pkg;

  localparam int PTM_NPT   = 64;
  localparam int PTM_LANES = 4;
  localparam int PTM_DW    = 16;

  // Twiddle exp(-j*2*pi*idx/npt), returned as {re[31:0], im[31:0]} in Q1.(dw-1).
  // Trigonometry is done with Taylor series in Q2.30 integer arithmetic.
  function automatic logic [63:0] tw_calc(input int idx, input int npt, input int dw);
    longint x, t, sn, cs, cr, sr, re, im, lim;
    int     quad, rem, sh;
    quad = (4 * idx) / npt;
    rem  = idx - quad * (npt / 4);
    x    = (longint'(rem) * 64'sd6746518852) / longint'(npt);
    sn   = x;
    t    = x;
    for (int k = 1; k < 8; k++) begin
      t  = (t * x) >>> 30;
      t  = (t * x) >>> 30;
      t  = -t / longint'((2 * k) * (2 * k + 1));
      sn = sn + t;
    end
    cs = 64'sd1 <<< 30;
    t  = cs;
    for (int k = 1; k < 8; k++) begin
      t  = (t * x) >>> 30;
      t  = (t * x) >>> 30;
      t  = -t / longint'((2 * k - 1) * (2 * k));
      cs = cs + t;
    end
    case (quad)
      0:       begin cr = cs;  sr = sn;  end
      1:       begin cr = -sn; sr = cs;  end
      2:       begin cr = -cs; sr = -sn; end
      default: begin cr = sn;  sr = -cs; end
    endcase
    sh  = 31 - dw;
    lim = (64'sd1 <<< (dw - 1)) - 1;
    re  = (cr + (64'sd1 <<< (sh - 1))) >>> sh;
    im  = (-sr + (64'sd1 <<< (sh - 1))) >>> sh;
    if (re > lim) re = lim;
    if (re < -lim - 1) re = -lim - 1;
    if (im > lim) im = lim;
    if (im < -lim - 1) im = -lim - 1;
    return {re[31:0], im[31:0]};
  endfunction

endpackage

// File: rtl/ptm_coef.sv
module ptm_coef
  import ptm_pkg::*;
#(
  parameter int NPT   = PTM_NPT,
  parameter int LANES = PTM_LANES,
  parameter int DW    = PTM_DW
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    adv,
  input  logic                    acc,
  input  logic                    pass_sel_i,
  input  logic [LANES*2*DW-1:0]   phase_i,
  output logic [LANES*2*DW-1:0]   coef_o
);

  localparam int BEATS = NPT / LANES;
  localparam int BW    = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int IW    = $clog2(NPT);
  localparam int CW    = 2 * DW;

  // Twiddle table, computed at elaboration
  logic [CW-1:0] rom [NPT];

  for (genvar m = 0; m < NPT; m++) begin : g_rom
    localparam logic [63:0] TW = tw_calc(m, NPT, DW);
    assign rom[m] = {TW[32 +: DW], TW[0 +: DW]};
  end

  // Beat position within the vector and the pass latched on its first beat
  logic [BW-1:0] beat_q;
  logic          pass_q;
  logic          first_beat;
  logic          use_phase;

  assign first_beat = (beat_q == '0);
  assign use_phase  = first_beat ? pass_sel_i : pass_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_q <= '0;
      pass_q <= 1'b0;
    end else if (acc) begin
      beat_q <= (beat_q == BW'(BEATS - 1)) ? '0 : beat_q + 1'b1;
      if (first_beat) pass_q <= pass_sel_i;
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [IW-1:0] idx;
    logic [CW-1:0] coef_q;

    assign idx = IW'((32'(beat_q) * k) % NPT);

    always_ff @(posedge clk) begin
      if (adv) coef_q <= use_phase ? phase_i[k*CW +: CW] : rom[idx];
    end

    assign coef_o[k*CW +: CW] = coef_q;
  end

endmodule

// File: rtl/ptm_lane.sv
module ptm_lane #(
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            adv,
  input  logic [2*DW-1:0] a_i,
  input  logic [2*DW-1:0] c_i,
  output logic [2*DW-1:0] y_o
);

  localparam int PW = 2 * DW;
  localparam int SW = 2 * DW + 1;
  localparam logic signed [SW-1:0] HALF = SW'(1) <<< (DW - 2);
  localparam logic signed [SW-1:0] MAXV = SW'((1 <<< (DW - 1)) - 1);
  localparam logic signed [SW-1:0] MINV = -MAXV - SW'(1);

  function automatic logic [DW-1:0] rnd_sat(input logic signed [SW-1:0] s);
    logic signed [SW-1:0] t;
    t = (s + HALF) >>> (DW - 1);
    if (t > MAXV) t = MAXV;
    else if (t < MINV) t = MINV;
    return t[DW-1:0];
  endfunction

  // stage 1: data register (coefficient registered alongside in ptm_coef)
  logic [2*DW-1:0] a1_q;
  always_ff @(posedge clk) begin
    if (adv) a1_q <= a_i;
  end

  logic signed [DW-1:0] ar, ai, cr, ci;
  assign ar = $signed(a1_q[2*DW-1:DW]);
  assign ai = $signed(a1_q[DW-1:0]);
  assign cr = $signed(c_i[2*DW-1:DW]);
  assign ci = $signed(c_i[DW-1:0]);

  // stage 2: four real products
  logic signed [PW-1:0] prr_q, pii_q, pri_q, pir_q;
  always_ff @(posedge clk) begin
    if (adv) begin
      prr_q <= ar * cr;
      pii_q <= ai * ci;
      pri_q <= ar * ci;
      pir_q <= ai * cr;
    end
  end

  // stage 3: combine, round, saturate
  logic signed [SW-1:0] sum_re, sum_im;
  assign sum_re = SW'(prr_q) - SW'(pii_q);
  assign sum_im = SW'(pri_q) + SW'(pir_q);

  always_ff @(posedge clk) begin
    if (adv) y_o <= {rnd_sat(sum_re), rnd_sat(sum_im)};
  end

endmodule

// File: rtl/phase_twiddle_mul.sv
module phase_twiddle_mul
  import ptm_pkg::*;
#(
  parameter int NPT   = PTM_NPT,
  parameter int LANES = PTM_LANES,
  parameter int DW    = PTM_DW
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  pass_sel_i,
  input  logic                  in_valid_i,
  output logic                  in_ready_o,
  input  logic [LANES*2*DW-1:0] data_i,
  input  logic [LANES*2*DW-1:0] phase_i,
  output logic                  out_valid_o,
  input  logic                  out_ready_i,
  output logic [LANES*2*DW-1:0] data_o
);

  localparam int CW  = 2 * DW;
  localparam int LAT = 3;

  logic [LAT-1:0]        vld_q;
  logic                  adv;
  logic                  acc;
  logic [LANES*CW-1:0]   coef;

  assign adv         = !vld_q[LAT-1] || out_ready_i;
  assign acc         = in_valid_i && adv;
  assign in_ready_o  = adv;
  assign out_valid_o = vld_q[LAT-1];

  always_ff @(posedge clk) begin
    if (rst) vld_q <= '0;
    else if (adv) vld_q <= {vld_q[LAT-2:0], acc};
  end

  ptm_coef #(.NPT(NPT), .LANES(LANES), .DW(DW)) coef_i (
    .clk        (clk),
    .rst        (rst),
    .adv        (adv),
    .acc        (acc),
    .pass_sel_i (pass_sel_i),
    .phase_i    (phase_i),
    .coef_o     (coef)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_mul
    ptm_lane #(.DW(DW)) lane_i (
      .clk (clk),
      .adv (adv),
      .a_i (data_i[k*CW +: CW]),
      .c_i (coef[k*CW +: CW]),
      .y_o (data_o[k*CW +: CW])
    );
  end

endmodule

// File: rtl/ptm_chk.sv
module ptm_chk #(
  parameter int LANES = 4,
  parameter int DW    = 16
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  in_valid_i,
  input logic                  in_ready_o,
  input logic                  out_valid_o,
  input logic                  out_ready_i,
  input logic [LANES*2*DW-1:0] data_o
);

  logic [2:0] inflight_q;
  logic       take, give;

  assign take = in_valid_i && in_ready_o;
  assign give = out_valid_o && out_ready_i;

  always_ff @(posedge clk) begin
    if (rst) inflight_q <= '0;
    else     inflight_q <= inflight_q + 3'(take) - 3'(give);
  end

  // R9
  depth_chk: assert property (@(posedge clk) disable iff (rst)
    inflight_q <= 3'd3);

  // R1
  no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
    (inflight_q == 3'd0) |-> !out_valid_o);

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(data_o)));

  // R10
  ready_chk: assert property (@(posedge clk) disable iff (rst)
    out_ready_i |-> in_ready_o);

endmodule

bind phase_twiddle_mul ptm_chk #(.LANES(LANES), .DW(DW)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .data_o      (data_o)
);

// File: tb/phase_twiddle_mul_tb_top.sv
module phase_twiddle_mul_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NPT   = 64;
  localparam int LANES = 4;
  localparam int DW    = 16;
  localparam int BEATS = NPT / LANES;
  localparam int BUS   = LANES * 2 * DW;
  localparam int NV    = 11;

  // {a_re, a_im, c_re, c_im, exp_re, exp_im}
  localparam logic [95:0] VEC [NV] = '{
    {16'(16384),  16'(0),      16'(16384),  16'(0),     16'(8192),   16'(0)},
    {16'(0),      16'(16384),  16'(0),      16'(16384), 16'(-8192),  16'(0)},
    {16'(-32768), 16'(0),      16'(-32768), 16'(0),     16'(32767),  16'(0)},
    {16'(-32768), 16'(-32768), 16'(-32768), 16'(32767), 16'(32767),  16'(1)},
    {16'(32767),  16'(32767),  16'(32767),  16'(32767), 16'(0),      16'(32767)},
    {16'(3),      16'(0),      16'(16384),  16'(0),     16'(2),      16'(0)},
    {16'(-3),     16'(0),      16'(16384),  16'(0),     16'(-1),     16'(0)},
    {16'(1000),   16'(-2000),  16'(32767),  16'(0),     16'(1000),   16'(-2000)},
    {16'(-32768), 16'(0),      16'(32767),  16'(0),     16'(-32767), 16'(0)},
    {16'(-32768), 16'(32767),  16'(32767),  16'(32767), 16'(-32768), 16'(-1)},
    {16'(100),    16'(200),    16'(0),      16'(16384), 16'(-100),   16'(50)}
  };

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           pass_sel_i = 1'b0;
  logic           in_valid_i = 1'b0;
  logic           in_ready_o;
  logic [BUS-1:0] data_i = '0;
  logic [BUS-1:0] phase_i = '0;
  logic           out_valid_o;
  logic           out_ready_i = 1'b0;
  logic [BUS-1:0] data_o;

  int checks = 0;
  int errors = 0;

  logic [BUS-1:0] exp_q [$];
  int             tol_q [$];
  string          req_q [$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  phase_twiddle_mul #(.NPT(NPT), .LANES(LANES), .DW(DW)) dut_i (
    .clk         (clk),
    .rst         (rst),
    .pass_sel_i  (pass_sel_i),
    .in_valid_i  (in_valid_i),
    .in_ready_o  (in_ready_o),
    .data_i      (data_i),
    .phase_i     (phase_i),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .data_o      (data_o)
  );

  function automatic logic [31:0] tw_exp(int m);
    real ang;
    int  re, im;
    ang = 2.0 * 3.14159265358979 * real'(m) / real'(NPT);
    re  = int'(32768.0 * $cos(ang));
    im  = int'(-32768.0 * $sin(ang));
    if (re > 32767) re = 32767;
    if (im > 32767) im = 32767;
    return {16'(re), 16'(im)};
  endfunction

  task automatic check(input bit ok, input string rq, input logic [BUS-1:0] act,
                       input logic [BUS-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic send(input logic [BUS-1:0] d, input logic [BUS-1:0] p, input logic ps,
                      input logic [BUS-1:0] e, input int tol, input string rq);
    data_i     = d;
    phase_i    = p;
    pass_sel_i = ps;
    in_valid_i = 1'b1;
    do @(negedge clk); while (!in_ready_o);
    exp_q.push_back(e);
    tol_q.push_back(tol);
    req_q.push_back(rq);
    @(posedge clk);
    #1;
    in_valid_i = 1'b0;
  endtask

  // output monitor
  always @(negedge clk) begin : mon
    logic [BUS-1:0] e;
    int    tol;
    string rq;
    bit    ok;
    if (!rst && out_valid_o && out_ready_i) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R10 unexpected beat", data_o, '0);
      end else begin
        e   = exp_q.pop_front();
        tol = tol_q.pop_front();
        rq  = req_q.pop_front();
        ok  = 1'b1;
        for (int c = 0; c < 2 * LANES; c++) begin
          int a, b;
          a = int'($signed(data_o[16*c +: 16]));
          b = int'($signed(e[16*c +: 16]));
          if (a - b > tol || b - a > tol) ok = 1'b0;
        end
        check(ok, rq, data_o, e);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [BUS-1:0] d, p, e;
    // R1: reset state with downstream not ready
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!out_valid_o && in_ready_o, "R1 reset state", {126'b0, out_valid_o, in_ready_o}, 128'h1);
    @(posedge clk); #1;
    rst = 1'b0;
    out_ready_i = 1'b1;

    // phase pass walked from the vector table (R2 R3 R4 R5 R8), selector low after beat 0
    for (int i = 0; i < BEATS; i++) begin
      for (int k = 0; k < LANES; k++) begin
        d[32*k +: 32] = VEC[(i + k) % NV][95:64];
        p[32*k +: 32] = VEC[(i + k) % NV][63:32];
        e[32*k +: 32] = VEC[(i + k) % NV][31:0];
      end
      send(d, p, (i == 0), e, 0, "R2 R3 R4 R5 R8 R7 phase pass");
    end

    // twiddle pass: selector high on later beats must be ignored (R6 R7)
    for (int i = 0; i < BEATS; i++) begin
      for (int k = 0; k < LANES; k++) begin
        d[32*k +: 32] = {16'(32767), 16'(0)};
        e[32*k +: 32] = tw_exp((i * k) % NPT);
      end
      send(d, '0, (i != 0), e, 2, "R6 R7 twiddle pass");
    end

    // R9: latency probe
    repeat (6) @(posedge clk); #1;
    for (int k = 0; k < LANES; k++) begin
      d[32*k +: 32] = VEC[0][95:64];
      p[32*k +: 32] = VEC[0][63:32];
      e[32*k +: 32] = VEC[0][31:0];
    end
    send(d, p, 1'b1, e, 0, "R9 latency data");
    @(negedge clk);
    check(!out_valid_o, "R9 early at t+1", {127'b0, out_valid_o}, '0);
    @(negedge clk);
    check(!out_valid_o, "R9 early at t+2", {127'b0, out_valid_o}, '0);
    @(negedge clk);
    check(out_valid_o, "R9 valid at t+3", {127'b0, out_valid_o}, 128'h1);
    @(posedge clk); #1;

    // R10: stall with three beats in flight
    out_ready_i = 1'b0;
    for (int j = 1; j <= 3; j++) begin
      for (int k = 0; k < LANES; k++) begin
        d[32*k +: 32] = VEC[j][95:64];
        p[32*k +: 32] = VEC[j][63:32];
        e[32*k +: 32] = VEC[j][31:0];
      end
      send(d, p, 1'b1, e, 0, "R10 order after stall");
    end
    for (int k = 0; k < LANES; k++) e[32*k +: 32] = VEC[1][31:0];
    @(negedge clk);
    check(!in_ready_o && out_valid_o, "R10 full pipe blocks input",
          {126'b0, in_ready_o, out_valid_o}, 128'h1);
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      check(out_valid_o && data_o == e, "R10 held output", data_o, e);
    end
    @(posedge clk); #1;
    out_ready_i = 1'b1;
    repeat (6) @(posedge clk); #1;

    // R1 R7: reset in mid-vector restarts the beat count
    for (int j = 4; j <= 5; j++) begin
      for (int k = 0; k < LANES; k++) begin
        d[32*k +: 32] = VEC[j][95:64];
        p[32*k +: 32] = VEC[j][63:32];
      end
      send(d, p, 1'b1, '0, 0, "R1 flushed");
    end
    rst = 1'b1;
    exp_q.delete();
    tol_q.delete();
    req_q.delete();
    repeat (2) @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
    check(!out_valid_o, "R1 flushed after reset", {127'b0, out_valid_o}, '0);
    @(posedge clk); #1;
    for (int i = 0; i < 2; i++) begin
      for (int k = 0; k < LANES; k++) begin
        d[32*k +: 32] = {16'(32767), 16'(0)};
        e[32*k +: 32] = tw_exp((i * k) % NPT);
      end
      send(d, '0, (i != 0), e, 2, "R1 R7 count restart");
    end
    repeat (8) @(posedge clk);
    check(exp_q.size() == 0, "R10 all beats delivered", 128'(exp_q.size()), '0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule